// File: doc/BRIEF.md
# Three-Aperture PCI Base Address Decoder

This block holds the base address registers of a PCI function that exposes two memory apertures and one I/O aperture. Configuration software probes each register by writing all ones and reading back a value that encodes the aperture size and type. It then programs a base address, which the block stores. A two-bit command field enables I/O space and memory space decoding.

Every incoming access presents an address and an I/O-or-memory qualifier. The block reports in the same cycle whether the access falls inside an enabled, mapped aperture, which aperture it hit, and the byte offset within it. When a configuration write actually moves an aperture's base, a one-cycle change pulse carrying the aperture index follows the write. Downstream logic can use this pulse to remap the aperture. A write that leaves the base unchanged produces no pulse.

The pulse comes from a two-state machine. ST_IDLE is the resting state. A base-changing write moves it to ST_NOTIFY (transition "announce"). In ST_NOTIFY the pulse is driven. Another base-changing write in that cycle keeps it in ST_NOTIFY (transition "re-announce"). Otherwise it returns to ST_IDLE (transition "settle"). Any other cycle in ST_IDLE stays in ST_IDLE (transition "rest").

Top module: `pci_aperture_decoder`

## Requirements
- R1: After reset, selectors 0, 1 and 2 read 0x00000000, 0x00000001 and 0x00000000. Selector 3 (command) reads 0. No access hits, and no change pulse is seen.
- R2: Writing 0xFFFFFFFF to selectors 0, 1 and 2 makes them read 0xFF000000, 0xFFFFFF01 and 0xFFFFF000. Each of these values is the two's complement of the aperture size (16 MB, 256 bytes, 4 KB) ORed with the aperture's type bit.
- R3: A write to selector k stores (data AND the aperture's size mask) OR its type bit, and a read returns the stored value. The type bit is bit 0, equal to 1 only for selector 1. The decoded base is the stored value with bits 3:0 cleared (memory) or bits 1:0 cleared (I/O).
- R4: Selector 3 is the command register. Bit 0 enables I/O decoding and bit 1 enables memory decoding. Only bits 1:0 are stored, and bits 31:2 read 0.
- R5: A memory access (acc_is_io=0) hits aperture 0 or 2 when command bit 1 is set and base <= addr < base+size. In that case hit_bar gives the index and hit_offset = addr - base, in the same cycle.
- R6: An I/O access hits aperture 1 only when command bit 0 is set and base <= addr < base+0x100. It then reports hit_bar=1 and the offset.
- R7: An aperture whose decoded base is zero produces no hit.
- R8: Memory accesses never hit aperture 1, and I/O accesses never hit apertures 0 or 2.
- R9: When memory apertures overlap, aperture 0 takes priority over aperture 2.
- R10: A write that changes an aperture's decoded base raises chg_valid for exactly the one cycle after the write edge, with chg_bar equal to the index. A write that leaves the base unchanged raises nothing.
- R11: Base-changing writes on consecutive cycles produce pulses on consecutive cycles, each carrying its own index.
- R12: Writes to the command register never raise chg_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register selector: 0-2 apertures, 3 command |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read value of the selected register |
| acc_valid | input | 1 | An access address is presented |
| acc_is_io | input | 1 | 1 for I/O space, 0 for memory space |
| acc_addr | input | 32 | Access address |
| hit_valid | output | 1 | Access falls in an enabled, mapped aperture |
| hit_bar | output | 2 | Index of the aperture hit |
| hit_offset | output | 32 | Byte offset of the access within the aperture |
| chg_valid | output | 1 | One-cycle pulse after a base change |
| chg_bar | output | 2 | Index of the aperture whose base changed |

## Verification
A corrupted stored base shows up at once on the read port. It also moves the hit window, so a probe just below the base, at the base, at the last byte or one past the end flips hit_valid or hit_offset in the same cycle. A wrong machine state shows up one cycle after a write: a missing, doubled or stray chg_valid pulse, or a wrong chg_bar. A lost command bit shows up as hits that appear or vanish across the four command settings, which are swept for every base.

// File: rtl/apdec_pkg.sv
package apdec_pkg;

    localparam int NUM_APER = 3;
    localparam int IDX_W    = 2;

    typedef logic [IDX_W-1:0] aper_idx_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_NOTIFY = 1'b1
    } notify_state_t;

    // selector value that addresses the command register
    localparam logic [IDX_W-1:0] SEL_CMD = 2'd3;

endpackage

// File: rtl/apdec_bar_slot.sv
module apdec_bar_slot #(
    parameter int ADDR_W   = 32,
    parameter int SIZE_LG2 = 24,
    parameter bit IS_IO    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              space_en,
    input  logic              acc_valid,
    input  logic              acc_is_io,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] stored,
    output logic [ADDR_W-1:0] base,
    output logic              chg_req,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    localparam logic [ADDR_W-1:0] SIZE_MASK = {ADDR_W{1'b1}} << SIZE_LG2;
    localparam logic [ADDR_W-1:0] TYPE_BIT  = ADDR_W'(IS_IO);
    localparam logic [ADDR_W-1:0] LOW_BITS  = IS_IO ? ADDR_W'(3) : ADDR_W'(15);

    logic [ADDR_W-1:0] stored_q;
    logic [ADDR_W-1:0] next_stored;
    logic [ADDR_W-1:0] next_base;

    always_comb begin
        next_stored = (wdata & SIZE_MASK) | TYPE_BIT;
        next_base   = next_stored & ~LOW_BITS;
        base        = stored_q & ~LOW_BITS;
        chg_req     = wr_en && (next_base != base);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= TYPE_BIT;
        end else if (wr_en) begin
            stored_q <= next_stored;
        end
    end

    assign stored = stored_q;

    always_comb begin
        hit    = acc_valid && (acc_is_io == IS_IO) && space_en &&
                 (base != '0) && ((acc_addr & SIZE_MASK) == base);
        offset = acc_addr & ~SIZE_MASK;
    end

    // R3: type bits keep their fixed value whatever software writes
    a_r3_type_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (stored_q & LOW_BITS) == TYPE_BIT);

    // R7: an unmapped aperture stays silent
    a_r7_zero_base_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (base == '0) |-> !hit);

    // R5: a hit always lies inside [base, base+size)
    a_r5_hit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((acc_addr - base) < (ADDR_W'(1) << SIZE_LG2)) && (acc_addr >= base));

endmodule

// File: rtl/apdec_notify_fsm.sv
module apdec_notify_fsm
    import apdec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      change_req,
    input  aper_idx_t change_idx,
    output logic      chg_valid,
    output aper_idx_t chg_bar
);

    notify_state_t state_q, state_d;
    aper_idx_t     idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = change_req ? ST_NOTIFY : ST_IDLE;
            ST_NOTIFY: state_d = change_req ? ST_NOTIFY : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (change_req) begin
                idx_q <= change_idx;
            end
        end
    end

    always_comb begin
        chg_valid = 1'b0;
        chg_bar   = '0;
        unique case (state_q)
            ST_IDLE: begin
                chg_valid = 1'b0;
                chg_bar   = '0;
            end
            ST_NOTIFY: begin
                chg_valid = 1'b1;
                chg_bar   = idx_q;
            end
            default: begin
                chg_valid = 1'b0;
                chg_bar   = '0;
            end
        endcase
    end

    // R10: a pulse appears exactly in the cycle after a base change
    a_r10_pulse_follows_change: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> $past(change_req));

    a_r10_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(change_req) |-> !chg_valid);

    // R11: each pulse carries the index of the write just before it
    a_r11_index_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> chg_bar == $past(change_idx));

endmodule

// File: rtl/pci_aperture_decoder.sv
module pci_aperture_decoder
    import apdec_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MEM0_LG2  = 24,
    parameter int IO_LG2    = 8,
    parameter int MEM2_LG2  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic              acc_is_io,
    input  logic [31:0]       acc_addr,
    output logic              hit_valid,
    output logic [1:0]        hit_bar,
    output logic [31:0]       hit_offset,
    output logic              chg_valid,
    output logic [1:0]        chg_bar
);

    logic [1:0]        cmd_q;
    logic [ADDR_W-1:0] stored [NUM_APER];
    logic [ADDR_W-1:0] base   [NUM_APER];
    logic [ADDR_W-1:0] offs   [NUM_APER];
    logic [NUM_APER-1:0] chg_vec;
    logic [NUM_APER-1:0] hit_vec;
    logic              any_chg;
    aper_idx_t         chg_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= 2'b00;
        end else if (cfg_wr && cfg_sel == SEL_CMD) begin
            cmd_q <= cfg_wdata[1:0];
        end
    end

    for (genvar i = 0; i < NUM_APER; i++) begin : g_aper
        localparam bit IS_IO = (i == 1);
        localparam int LG2   = (i == 0) ? MEM0_LG2 : (i == 1) ? IO_LG2 : MEM2_LG2;

        apdec_bar_slot #(
            .ADDR_W   (ADDR_W),
            .SIZE_LG2 (LG2),
            .IS_IO    (IS_IO)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_wr && cfg_sel == IDX_W'(i)),
            .wdata     (cfg_wdata),
            .space_en  (IS_IO ? cmd_q[0] : cmd_q[1]),
            .acc_valid (acc_valid),
            .acc_is_io (acc_is_io),
            .acc_addr  (acc_addr),
            .stored    (stored[i]),
            .base      (base[i]),
            .chg_req   (chg_vec[i]),
            .hit       (hit_vec[i]),
            .offset    (offs[i])
        );
    end

    // lowest index wins when windows overlap
    always_comb begin
        hit_valid  = 1'b0;
        hit_bar    = '0;
        hit_offset = '0;
        for (int k = NUM_APER - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                hit_valid  = 1'b1;
                hit_bar    = IDX_W'(k);
                hit_offset = offs[k];
            end
        end
    end

    always_comb begin
        any_chg = |chg_vec;
        chg_idx = '0;
        for (int k = 0; k < NUM_APER; k++) begin
            if (chg_vec[k]) begin
                chg_idx = IDX_W'(k);
            end
        end
    end

    always_comb begin
        unique case (cfg_sel)
            2'd0:    cfg_rdata = stored[0];
            2'd1:    cfg_rdata = stored[1];
            2'd2:    cfg_rdata = stored[2];
            default: cfg_rdata = {30'd0, cmd_q};
        endcase
    end

    apdec_notify_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .change_req (any_chg),
        .change_idx (chg_idx),
        .chg_valid  (chg_valid),
        .chg_bar    (chg_bar)
    );

    // R10: only one aperture can request a change per cycle
    a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg_vec));

    // R6: I/O hits need the I/O enable and land on aperture 1
    a_r6_io_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && acc_is_io) |-> (cmd_q[0] && hit_bar == 2'd1));

    // R8: memory hits need the memory enable and avoid aperture 1
    a_r8_mem_not_io_bar: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !acc_is_io) |-> (cmd_q[1] && hit_bar != 2'd1));

    // R9: overlap resolves toward aperture 0
    a_r9_priority: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[0] |-> hit_bar == 2'd0);

endmodule

// File: tb/sim_pci_aperture_decoder.sv
`timescale 1ns/1ps
module sim_pci_aperture_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_is_io = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        hit_valid;
    logic [1:0]  hit_bar;
    logic [31:0] hit_offset;
    logic        chg_valid;
    logic [1:0]  chg_bar;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_stored [3];
    logic [1:0]  m_cmd;

    always #2.5 clk = ~clk;

    pci_aperture_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_is_io(acc_is_io), .acc_addr(acc_addr), .hit_valid(hit_valid),
        .hit_bar(hit_bar), .hit_offset(hit_offset), .chg_valid(chg_valid),
        .chg_bar(chg_bar)
    );

    function automatic int lg2_of(int i);
        return (i == 0) ? 24 : (i == 1) ? 8 : 12;
    endfunction

    function automatic logic [31:0] mbase(int i);
        return m_stored[i] & ((i == 1) ? 32'hFFFF_FFFC : 32'hFFFF_FFF0);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic read_chk(string req, logic [1:0] sel, logic [31:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    // write, then check pulse one cycle after the write edge and its end
    task automatic write_chk(logic [1:0] sel, logic [31:0] data);
        logic [31:0] old_b;
        logic [31:0] mask;
        bit moved;
        old_b = (sel == 2'd3) ? 32'd0 : mbase(int'(sel));
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sel == 2'd3) begin
            m_cmd = data[1:0];
            moved = 1'b0;
            check("R12", {31'd0, chg_valid}, 32'd0);
        end else begin
            mask = 32'hFFFF_FFFF << lg2_of(int'(sel));
            m_stored[sel] = (data & mask) | ((sel == 2'd1) ? 32'd1 : 32'd0);
            moved = (mbase(int'(sel)) != old_b);
            check("R10", {31'd0, chg_valid}, {31'd0, moved});
            if (moved) check("R10", {30'd0, chg_bar}, {30'd0, sel});
        end
        @(negedge clk);
        check("R10", {31'd0, chg_valid}, 32'd0);
    endtask

    task automatic probe(logic [31:0] addr, logic io);
        bit e_hit;
        logic [1:0] e_bar;
        logic [32:0] e_off;
        logic [32:0] a33;
        logic [32:0] b33;
        e_hit = 1'b0; e_bar = 2'd0; e_off = '0;
        a33 = {1'b0, addr};
        for (int i = 2; i >= 0; i--) begin
            b33 = {1'b0, mbase(i)};
            if ((io == (i == 1)) && (io ? m_cmd[0] : m_cmd[1]) && mbase(i) != 0 &&
                a33 >= b33 && (a33 - b33) < (33'd1 << lg2_of(i))) begin
                e_hit = 1'b1; e_bar = 2'(i); e_off = a33 - b33;
            end
        end
        @(negedge clk);
        acc_valid = 1'b1; acc_is_io = io; acc_addr = addr;
        #1;
        check(io ? "R6" : "R5", {31'd0, hit_valid}, {31'd0, e_hit});
        if (e_hit) begin
            check(io ? "R6" : "R5", {30'd0, hit_bar}, {30'd0, e_bar});
            check(io ? "R6" : "R5", hit_offset, e_off[31:0]);
        end
        acc_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        m_stored[0] = 0; m_stored[1] = 1; m_stored[2] = 0; m_cmd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_chk("R1", 2'd0, 32'h0);
        read_chk("R1", 2'd1, 32'h1);
        read_chk("R1", 2'd2, 32'h0);
        read_chk("R1", 2'd3, 32'h0);
        check("R1", {31'd0, chg_valid}, 32'd0);
        probe(32'h0, 1'b0);

        // R2 sizing probes
        write_chk(2'd0, 32'hFFFF_FFFF); read_chk("R2", 2'd0, 32'hFF00_0000);
        write_chk(2'd1, 32'hFFFF_FFFF); read_chk("R2", 2'd1, 32'hFFFF_FF01);
        write_chk(2'd2, 32'hFFFF_FFFF); read_chk("R2", 2'd2, 32'hFFFF_F000);

        // R3 masking of written values
        write_chk(2'd1, 32'h1234_5678); read_chk("R3", 2'd1, 32'h1234_5601);
        write_chk(2'd2, 32'h1234_5678); read_chk("R3", 2'd2, 32'h1234_5000);
        write_chk(2'd2, 32'h1234_5FFF); read_chk("R3", 2'd2, 32'h1234_5000);

        // R4 command register
        write_chk(2'd3, 32'hFFFF_FFFF); read_chk("R4", 2'd3, 32'h3);
        write_chk(2'd3, 32'h0000_0002); read_chk("R4", 2'd3, 32'h2);

        // R5/R6/R7 sweep: one aperture mapped at a time, every command setting
        for (int i = 0; i < 3; i++) begin
            for (int k = 0; k < 3; k++) write_chk(2'(k), 32'h0);
            for (int b = lg2_of(i); b <= 32; b++) begin
                logic [31:0] bv;
                logic [31:0] sz;
                bv = (b == 32) ? (32'hFFFF_FFFF << lg2_of(i)) : (32'd1 << b);
                sz = 32'd1 << lg2_of(i);
                write_chk(2'(i), bv);
                read_chk("R3", 2'(i), bv | ((i == 1) ? 32'd1 : 32'd0));
                for (int c = 0; c < 4; c++) begin
                    write_chk(2'd3, 32'(c));
                    for (int io = 0; io < 2; io++) begin
                        probe(bv - 1, io[0]);
                        probe(bv, io[0]);
                        probe(bv + sz - 1, io[0]);
                        probe(bv + sz, io[0]);
                    end
                end
            end
        end

        // R7: zero base silent even with both enables
        for (int k = 0; k < 3; k++) write_chk(2'(k), 32'h0);
        write_chk(2'd3, 32'h3);
        @(negedge clk); acc_valid = 1; acc_is_io = 0; acc_addr = 32'h10; #1;
        check("R7", {31'd0, hit_valid}, 32'd0);
        acc_is_io = 1; #1;
        check("R7", {31'd0, hit_valid}, 32'd0);
        acc_valid = 0;

        // R8: I/O window probed as memory and vice versa
        write_chk(2'd1, 32'h0000_4000);
        @(negedge clk); acc_valid = 1; acc_is_io = 0; acc_addr = 32'h0000_4004; #1;
        check("R8", {31'd0, hit_valid}, 32'd0);
        acc_valid = 0;
        write_chk(2'd2, 32'h0000_8000);
        @(negedge clk); acc_valid = 1; acc_is_io = 1; acc_addr = 32'h0000_8004; #1;
        check("R8", {31'd0, hit_valid}, 32'd0);
        acc_valid = 0;

        // R9: overlapping memory windows
        write_chk(2'd0, 32'h1000_0000);
        write_chk(2'd2, 32'h1000_1000);
        @(negedge clk); acc_valid = 1; acc_is_io = 0; acc_addr = 32'h1000_1010; #1;
        check("R9", {30'd0, hit_bar}, 32'd0);
        check("R9", hit_offset, 32'h0000_1010);
        acc_valid = 0;

        // R10: rewriting the same base gives no pulse
        write_chk(2'd2, 32'h1000_1ABC);

        // R11: back-to-back base changes
        @(negedge clk);
        cfg_wr = 1; cfg_sel = 2'd0; cfg_wdata = 32'h2000_0000;
        @(negedge clk);
        check("R11", {30'd0, chg_bar, chg_valid}, 32'b001);
        cfg_sel = 2'd2; cfg_wdata = 32'h3000_0000;
        @(negedge clk);
        cfg_wr = 0;
        check("R11", {30'd0, chg_bar, chg_valid}, 32'b101);
        @(negedge clk);
        check("R11", {31'd0, chg_valid}, 32'd0);
        m_stored[0] = 32'h2000_0000; m_stored[2] = 32'h3000_0000;
        probe(32'h2000_0044, 1'b0);
        probe(32'h3000_0044, 1'b0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule